// File: doc/BRIEF.md
# Variable Element Width Integer ALU

This block is an integer ALU whose working width is chosen for each operation by an element-width input. When the element width is narrower than the register width, the ALU first extends both operands from that width. The sign flag chooses sign extension or zero extension. The ALU then performs the operation on the extended values and extends the result again from the same width. As a result, bits above the element width in the inputs never affect the answer, and the output always holds a correctly extended element.

The ALU supports add, subtract, the three bitwise logic operations, left and right shifts, low multiply, two multiply-high forms, and five comparisons. A comparison drives a one-bit flag rather than the data result. The result and the flag are registered, so an operation presented before a rising clock edge appears on the outputs after that edge.

Top module: `vew_int_alu`

## Requirements
- R1: When the element width is 0, equals the register-width input, or is at least 64, the operation runs in full mode. In full mode neither operand nor the result is extended. For example, an add wraps at 64 bits, and with a 32-bit register width and element width 32 the carry into bit 32 is kept.
- R2: In narrow mode, bits of either operand above the element width have no effect on the result or on the compare flag.
- R3: In narrow mode, every data result is re-extended from the element width. With the sign flag at 1 every bit above the element width copies the element's top bit. With the sign flag at 0 those bits are zero.
- R4: The shift amount is the low 6 bits of operand b ANDed with (element width − 1) in narrow mode, or with (register width − 1) in full mode. Code 5 shifts left. Code 6 shifts the extended operand right, filling with zeros.
- R5: Narrow multiply-high (code 8, or code 9) forms the low 64 bits of the product of the extended operands. It shifts that value right by min(element width, 32), keeps only that many low bits, and then re-extends as in R3.
- R6: Full multiply-high returns the upper 64 bits of the 128-bit product. Code 8 treats both operands as signed when the sign flag is 1 and as unsigned when it is 0. Code 9 always treats operand a as signed and operand b as unsigned.
- R7: Codes 10 to 14 are less-than, greater-than, greater-or-equal, equal and not-equal. They act on the extended operands and are signed when the sign flag is 1. A comparison sets the data result to 0. Every non-compare code drives the compare flag to 0.
- R8: Operation codes are 0 add, 1 subtract, 2 and, 3 or, 4 xor, 5 shift left, 6 shift right, 7 multiply low, 8 multiply-high, 9 multiply-high signed-by-unsigned, 10 to 14 compares, and 15 unused. Code 15 yields a result of 0 and a flag of 0.
- R9: The outputs update one clock edge after the inputs. An active-low asynchronous reset clears both outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| bw_i | input | 7 | Element width in bits (0 selects full mode) |
| sgn_i | input | 1 | 1 selects sign extension and signed compare or multiply-high |
| xlen_i | input | 7 | Register width in use (32 or 64) |
| a_i | input | 64 | Operand a |
| b_i | input | 64 | Operand b, also the shift amount |
| res_o | output | 64 | Registered data result |
| cmp_o | output | 1 | Registered compare flag |

## Verification
The hardest case to reach from the ports is the interaction of extension with the multiply-high cut. The cut of min(width, 32) bits lands differently for widths below 32 and above 32. The re-extension after the cut can also turn a narrow signed high part into all ones. The stimulus table therefore drives multiply-high at widths 8, 16 and 48 with hand-computed products, including a negative operand. It also drives operands whose upper bits are deliberately non-zero, so that a missing or wrongly placed extension changes the visible result.

// File: rtl/vew_alu_pkg.sv
package vew_alu_pkg;

    localparam int XLEN = 64;
    localparam int BW_W = $clog2(XLEN) + 1;

    typedef enum logic [3:0] {
        OP_ADD    = 4'd0,
        OP_SUB    = 4'd1,
        OP_AND    = 4'd2,
        OP_OR     = 4'd3,
        OP_XOR    = 4'd4,
        OP_SLL    = 4'd5,
        OP_SRL    = 4'd6,
        OP_MUL    = 4'd7,
        OP_MULH   = 4'd8,
        OP_MULHSU = 4'd9,
        OP_LT     = 4'd10,
        OP_GT     = 4'd11,
        OP_GE     = 4'd12,
        OP_EQ     = 4'd13,
        OP_NE     = 4'd14,
        OP_NONE   = 4'd15
    } vew_op_e;

    typedef struct packed {
        logic [XLEN-1:0] res;
        logic            cmp;
    } vew_out_t;

endpackage

// File: rtl/vew_extend.sv
// Extends a value from a run-time bit width, by sign or by zero.
module vew_extend #(
    parameter int XLEN = vew_alu_pkg::XLEN,
    parameter int BW_W = $clog2(XLEN) + 1
) (
    input  logic [XLEN-1:0] val_i,
    input  logic [BW_W-1:0] bw_i,
    input  logic            sgn_i,
    output logic [XLEN-1:0] ext_o
);
    localparam int IDX_W = $clog2(XLEN);

    logic [XLEN-1:0]  keep;
    logic [IDX_W-1:0] top_idx;
    logic             top_bit;

    always_comb begin
        for (int i = 0; i < XLEN; i++) begin
            keep[i] = (BW_W'(i) < bw_i);
        end
        top_idx = IDX_W'(bw_i - 1'b1);
        top_bit = (bw_i != '0) && val_i[top_idx];
        ext_o   = (sgn_i && top_bit) ? (val_i | ~keep) : (val_i & keep);
    end
endmodule

// File: rtl/vew_operand_prep.sv
// Decides full or narrow mode and extends both operands for narrow mode.
module vew_operand_prep
    import vew_alu_pkg::*;
#(
    parameter int XLEN = vew_alu_pkg::XLEN,
    parameter int BW_W = $clog2(XLEN) + 1
) (
    input  vew_op_e         op_i,
    input  logic [BW_W-1:0] bw_i,
    input  logic            sgn_i,
    input  logic [BW_W-1:0] xlen_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    output logic            narrow_o,
    output logic            a_signed_o,
    output logic            b_signed_o,
    output logic [XLEN-1:0] a_o,
    output logic [XLEN-1:0] b_o
);
    logic [XLEN-1:0] src    [2];
    logic [XLEN-1:0] ext    [2];
    logic            sg     [2];

    always_comb begin
        narrow_o   = (bw_i != '0) && (bw_i != xlen_i) && (bw_i < BW_W'(XLEN));
        // signed-by-unsigned multiply-high fixes each operand's signedness
        a_signed_o = (op_i == OP_MULHSU) ? 1'b1 : sgn_i;
        b_signed_o = (op_i == OP_MULHSU) ? 1'b0 : sgn_i;
        src[0]     = a_i;
        src[1]     = b_i;
        sg[0]      = a_signed_o;
        sg[1]      = b_signed_o;
    end

    for (genvar k = 0; k < 2; k++) begin : g_ext
        vew_extend #(.XLEN(XLEN), .BW_W(BW_W)) u_ext (
            .val_i (src[k]),
            .bw_i  (bw_i),
            .sgn_i (sg[k]),
            .ext_o (ext[k])
        );
    end

    always_comb begin
        a_o = narrow_o ? ext[0] : a_i;
        b_o = narrow_o ? ext[1] : b_i;
    end
endmodule

// File: rtl/vew_compute.sv
// Performs the selected operation on already prepared operands.
module vew_compute
    import vew_alu_pkg::*;
#(
    parameter int XLEN = vew_alu_pkg::XLEN,
    parameter int BW_W = $clog2(XLEN) + 1
) (
    input  vew_op_e         op_i,
    input  logic            narrow_i,
    input  logic [BW_W-1:0] bw_i,
    input  logic [BW_W-1:0] xlen_i,
    input  logic            sgn_i,
    input  logic            a_signed_i,
    input  logic            b_signed_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    output logic [XLEN-1:0] res_o,
    output logic            cmp_o,
    output logic            is_cmp_o
);
    localparam int SH_W = $clog2(XLEN);
    localparam int HALF = XLEN / 2;

    logic [SH_W-1:0]   sh_lim;
    logic [SH_W-1:0]   shamt;
    logic [2*XLEN-1:0] a_wide;
    logic [2*XLEN-1:0] b_wide;
    logic [2*XLEN-1:0] prod;
    logic [BW_W-1:0]   cut;
    logic [XLEN-1:0]   hi_keep;
    logic [XLEN-1:0]   narrow_hi;
    logic [XLEN-1:0]   high_part;
    logic              lt;
    logic              eq;

    always_comb begin
        sh_lim = narrow_i ? SH_W'(bw_i - 1'b1) : SH_W'(xlen_i - 1'b1);
        shamt  = b_i[SH_W-1:0] & sh_lim;

        a_wide = {{XLEN{a_signed_i & a_i[XLEN-1]}}, a_i};
        b_wide = {{XLEN{b_signed_i & b_i[XLEN-1]}}, b_i};
        prod   = a_wide * b_wide;

        cut = (narrow_i && (bw_i < BW_W'(HALF))) ? bw_i : BW_W'(HALF);
        for (int i = 0; i < XLEN; i++) begin
            hi_keep[i] = (BW_W'(i) < cut);
        end
        narrow_hi = (prod[XLEN-1:0] >> cut) & hi_keep;
        high_part = narrow_i ? narrow_hi : prod[2*XLEN-1:XLEN];

        lt = sgn_i ? ($signed(a_i) < $signed(b_i)) : (a_i < b_i);
        eq = (a_i == b_i);

        res_o    = '0;
        cmp_o    = 1'b0;
        is_cmp_o = 1'b0;
        unique case (op_i)
            OP_ADD:    res_o = a_i + b_i;
            OP_SUB:    res_o = a_i - b_i;
            OP_AND:    res_o = a_i & b_i;
            OP_OR:     res_o = a_i | b_i;
            OP_XOR:    res_o = a_i ^ b_i;
            OP_SLL:    res_o = a_i << shamt;
            OP_SRL:    res_o = a_i >> shamt;
            OP_MUL:    res_o = prod[XLEN-1:0];
            OP_MULH:   res_o = high_part;
            OP_MULHSU: res_o = high_part;
            OP_LT: begin is_cmp_o = 1'b1; cmp_o = lt;         end
            OP_GT: begin is_cmp_o = 1'b1; cmp_o = !lt && !eq; end
            OP_GE: begin is_cmp_o = 1'b1; cmp_o = !lt;        end
            OP_EQ: begin is_cmp_o = 1'b1; cmp_o = eq;         end
            OP_NE: begin is_cmp_o = 1'b1; cmp_o = !eq;        end
            default:   res_o = '0;
        endcase
    end
endmodule

// File: rtl/vew_int_alu.sv
module vew_int_alu
    import vew_alu_pkg::*;
#(
    parameter int XLEN = vew_alu_pkg::XLEN,
    parameter int BW_W = $clog2(XLEN) + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [3:0]      op_i,
    input  logic [BW_W-1:0] bw_i,
    input  logic            sgn_i,
    input  logic [BW_W-1:0] xlen_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    output logic [XLEN-1:0] res_o,
    output logic            cmp_o
);
    typedef struct packed {
        logic [XLEN-1:0] res;
        logic            cmp;
    } stage_t;

    vew_op_e         op;
    logic            narrow_w;
    logic            a_signed_w;
    logic            b_signed_w;
    logic [XLEN-1:0] a_prep;
    logic [XLEN-1:0] b_prep;
    logic [XLEN-1:0] raw_res;
    logic [XLEN-1:0] fixed_res;
    logic            raw_cmp;
    logic            is_cmp_w;
    stage_t          st_d;
    stage_t          st_q;

    assign op = vew_op_e'(op_i);

    vew_operand_prep #(.XLEN(XLEN), .BW_W(BW_W)) u_prep (
        .op_i       (op),
        .bw_i       (bw_i),
        .sgn_i      (sgn_i),
        .xlen_i     (xlen_i),
        .a_i        (a_i),
        .b_i        (b_i),
        .narrow_o   (narrow_w),
        .a_signed_o (a_signed_w),
        .b_signed_o (b_signed_w),
        .a_o        (a_prep),
        .b_o        (b_prep)
    );

    vew_compute #(.XLEN(XLEN), .BW_W(BW_W)) u_compute (
        .op_i       (op),
        .narrow_i   (narrow_w),
        .bw_i       (bw_i),
        .xlen_i     (xlen_i),
        .sgn_i      (sgn_i),
        .a_signed_i (a_signed_w),
        .b_signed_i (b_signed_w),
        .a_i        (a_prep),
        .b_i        (b_prep),
        .res_o      (raw_res),
        .cmp_o      (raw_cmp),
        .is_cmp_o   (is_cmp_w)
    );

    // result re-extension from the element width
    vew_extend #(.XLEN(XLEN), .BW_W(BW_W)) u_fix (
        .val_i (raw_res),
        .bw_i  (bw_i),
        .sgn_i (sgn_i),
        .ext_o (fixed_res)
    );

    always_comb begin
        st_d     = '0;
        st_d.cmp = raw_cmp;
        if (!is_cmp_w) begin
            st_d.res = narrow_w ? fixed_res : raw_res;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_o = st_q.res;
    assign cmp_o = st_q.cmp;

    function automatic logic upper_matches(input logic [XLEN-1:0] v,
                                           input logic [BW_W-1:0] w,
                                           input logic            s);
        logic ok;
        logic tb;
        ok = 1'b1;
        tb = s && (w != '0) && v[$clog2(XLEN)'(w - 1'b1)];
        for (int i = 0; i < XLEN; i++) begin
            if ((BW_W'(i) >= w) && (v[i] != tb)) ok = 1'b0;
        end
        return ok;
    endfunction

    AST_NARROW_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (narrow_w && sgn_i && !is_cmp_w) |=> upper_matches(res_o, $past(bw_i), 1'b1)); // R3
    AST_NARROW_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (narrow_w && !sgn_i && !is_cmp_w) |=> upper_matches(res_o, $past(bw_i), 1'b0)); // R3
    AST_CMP_RES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i inside {4'd10, 4'd11, 4'd12, 4'd13, 4'd14}) |=> (res_o == '0)); // R7
    AST_CMP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i < 4'd10 || op_i == 4'd15) |=> !cmp_o); // R7
    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd15) |=> (res_o == '0 && !cmp_o)); // R8
endmodule

// File: tb/vew_int_alu_bench.sv
module vew_int_alu_bench;
    import vew_alu_pkg::*;

    localparam int XL  = 64;
    localparam int BWW = 7;
    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

    typedef struct packed {
        logic [3:0]  op;
        logic [6:0]  bw;
        logic        sg;
        logic [6:0]  xl;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] er;
        logic        ec;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 33;
    localparam vec_t VECS [NV] = '{
        '{OP_ADD,    7'd0,  1'b0, 7'd64, ONES, 64'd1, 64'd0, 1'b0, 4'd1},              // R1 wrap
        '{OP_ADD,    7'd64, 1'b1, 7'd64, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 64'h8000_0000_0000_0000, 1'b0, 4'd1}, // R1
        '{OP_ADD,    7'd32, 1'b0, 7'd32, 64'hFFFF_FFFF, 64'd1, 64'h1_0000_0000, 1'b0, 4'd1}, // R1 bw==xlen
        '{OP_ADD,    7'd32, 1'b0, 7'd64, 64'hFFFF_FFFF, 64'd1, 64'd0, 1'b0, 4'd3},       // R3
        '{OP_ADD,    7'd8,  1'b1, 7'd64, 64'h7F, 64'd1, 64'hFFFF_FFFF_FFFF_FF80, 1'b0, 4'd3}, // R3
        '{OP_SUB,    7'd16, 1'b1, 7'd64, 64'd0, 64'd1, ONES, 1'b0, 4'd3},                // R3
        '{OP_XOR,    7'd16, 1'b0, 7'd64, 64'hFFFF_0000_0000_1234, 64'hFF, 64'h12CB, 1'b0, 4'd2}, // R2
        '{OP_AND,    7'd8,  1'b0, 7'd64, 64'hF0F0, 64'hFFFF, 64'hF0, 1'b0, 4'd2},       // R2
        '{OP_OR,     7'd4,  1'b1, 7'd64, 64'h8, 64'h1, 64'hFFFF_FFFF_FFFF_FFF9, 1'b0, 4'd3}, // R3
        '{OP_SLL,    7'd8,  1'b0, 7'd64, 64'd1, 64'd9, 64'd2, 1'b0, 4'd4},              // R4 narrow mask
        '{OP_SLL,    7'd0,  1'b0, 7'd64, 64'd1, 64'd65, 64'd2, 1'b0, 4'd4},             // R4 full mask 63
        '{OP_SLL,    7'd0,  1'b0, 7'd32, 64'd1, 64'd33, 64'd2, 1'b0, 4'd4},             // R4 full mask 31
        '{OP_SLL,    7'd0,  1'b0, 7'd64, 64'd1, 64'd40, 64'h100_0000_0000, 1'b0, 4'd4}, // R4
        '{OP_SRL,    7'd8,  1'b1, 7'd64, 64'h80, 64'd1, 64'hFFFF_FFFF_FFFF_FFC0, 1'b0, 4'd4}, // R4
        '{OP_SRL,    7'd8,  1'b0, 7'd64, 64'h80, 64'd1, 64'h40, 1'b0, 4'd4},             // R4
        '{OP_MUL,    7'd8,  1'b1, 7'd64, 64'h10, 64'h10, 64'd0, 1'b0, 4'd3},            // R3
        '{OP_MUL,    7'd0,  1'b0, 7'd64, 64'h1_0000_0000, 64'h1_0000_0000, 64'd0, 1'b0, 4'd1}, // R1
        '{OP_MULH,   7'd8,  1'b1, 7'd64, 64'hFE, 64'd3, ONES, 1'b0, 4'd5},              // R5
        '{OP_MULH,   7'd16, 1'b0, 7'd64, 64'hFFFF, 64'hFFFF, 64'hFFFE, 1'b0, 4'd5},     // R5
        '{OP_MULH,   7'd48, 1'b0, 7'd64, 64'h1_0000_0000, 64'd3, 64'd3, 1'b0, 4'd5},    // R5 cut 32
        '{OP_MULHSU, 7'd8,  1'b0, 7'd64, 64'hFE, 64'd3, 64'hFF, 1'b0, 4'd5},            // R5
        '{OP_MULH,   7'd0,  1'b1, 7'd64, ONES, 64'd2, ONES, 1'b0, 4'd6},                // R6
        '{OP_MULH,   7'd0,  1'b0, 7'd64, ONES, 64'd2, 64'd1, 1'b0, 4'd6},               // R6
        '{OP_MULHSU, 7'd0,  1'b0, 7'd64, ONES, 64'd2, ONES, 1'b0, 4'd6},                // R6
        '{OP_LT,     7'd8,  1'b1, 7'd64, 64'h80, 64'd1, 64'd0, 1'b1, 4'd7},             // R7
        '{OP_LT,     7'd8,  1'b0, 7'd64, 64'h80, 64'd1, 64'd0, 1'b0, 4'd7},             // R7
        '{OP_EQ,     7'd8,  1'b0, 7'd64, 64'hAB00_0000_0000_0005, 64'd5, 64'd0, 1'b1, 4'd2}, // R2
        '{OP_EQ,     7'd0,  1'b0, 7'd64, 64'hAB00_0000_0000_0005, 64'd5, 64'd0, 1'b0, 4'd1}, // R1
        '{OP_GT,     7'd0,  1'b1, 7'd64, ONES, 64'd1, 64'd0, 1'b0, 4'd7},               // R7
        '{OP_GT,     7'd0,  1'b0, 7'd64, ONES, 64'd1, 64'd0, 1'b1, 4'd7},               // R7
        '{OP_GE,     7'd16, 1'b0, 7'd64, 64'h1234, 64'h1234, 64'd0, 1'b1, 4'd7},        // R7
        '{OP_NE,     7'd16, 1'b0, 7'd64, 64'hFFFF_0000_0000_1234, 64'h1234, 64'd0, 1'b0, 4'd2}, // R2
        '{OP_NONE,   7'd0,  1'b0, 7'd64, 64'd5, 64'd7, 64'd0, 1'b0, 4'd8}               // R8
    };

    logic            clk = 1'b0;
    logic            rst_n;
    logic [3:0]      op_i;
    logic [BWW-1:0]  bw_i;
    logic            sgn_i;
    logic [BWW-1:0]  xlen_i;
    logic [XL-1:0]   a_i;
    logic [XL-1:0]   b_i;
    logic [XL-1:0]   res_o;
    logic            cmp_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    vew_int_alu u_vew_int_alu (
        .clk    (clk),
        .rst_n  (rst_n),
        .op_i   (op_i),
        .bw_i   (bw_i),
        .sgn_i  (sgn_i),
        .xlen_i (xlen_i),
        .a_i    (a_i),
        .b_i    (b_i),
        .res_o  (res_o),
        .cmp_o  (cmp_o)
    );

    task automatic check(input string tag, input logic [63:0] er, input logic ec);
        n_checks++;
        if (res_o !== er || cmp_o !== ec) begin
            n_fail++;
            $display("FAIL %s: res=%h cmp=%b expected res=%h cmp=%b", tag, res_o, cmp_o, er, ec);
        end
    endtask

    task automatic drive(input logic [3:0] op, input logic [6:0] bw, input logic sg,
                         input logic [6:0] xl, input logic [63:0] a, input logic [63:0] b);
        op_i = op; bw_i = bw; sgn_i = sg; xlen_i = xl; a_i = a; b_i = b;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        drive(4'd0, 7'd0, 1'b0, 7'd64, 64'd3, 64'd4);
        repeat (3) @(negedge clk);
        check("R9 reset state", 64'd0, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i].op, VECS[i].bw, VECS[i].sg, VECS[i].xl, VECS[i].a, VECS[i].b);
            @(negedge clk);
            check($sformatf("R%0d vector %0d", VECS[i].rq, i), VECS[i].er, VECS[i].ec);
        end

        // R9: back-to-back operations each appear one edge later
        @(negedge clk);
        drive(OP_ADD, 7'd0, 1'b0, 7'd64, 64'd1, 64'd1);
        @(negedge clk);
        check("R9 first of pair", 64'd2, 1'b0);
        drive(OP_EQ, 7'd0, 1'b0, 7'd64, 64'd9, 64'd9);
        @(negedge clk);
        check("R9 second of pair", 64'd0, 1'b1);

        // R2: garbage above width ignored in shift amount and operand a
        drive(OP_SLL, 7'd16, 1'b0, 7'd64, 64'hDEAD_0000_0000_0003, 64'hFF00_0000_0000_0002);
        @(negedge clk);
        check("R2 shift with upper garbage", 64'hC, 1'b0);

        // R9: asynchronous reset clears outputs mid-run
        drive(OP_ADD, 7'd0, 1'b0, 7'd64, 64'd20, 64'd22);
        @(negedge clk);
        check("R9 before reset", 64'd42, 1'b0);
        rst_n = 1'b0;
        #2;
        check("R9 async clear", 64'd0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule